// File: doc/BRIEF.md
# Read-Snoop Data Termination Controller

This block drives the data-line on-die termination enable of one DRAM device that shares its command bus with other ranks. Every cycle it looks at the command lines, and it recognises a read burst whether or not the chip select picks this device. Because every rank on the bus runs the same logic, a read to any rank switches off the data terminators of all of them. This keeps the bus from being loaded by several terminations while read data is on it.

The turn-off follows the read command by CAS latency minus one cycles, which lines up with the start of the read data. The CAS latency is a run-time input. The terminators stay off for the burst length in cycles plus one guard cycle. A further read that lands inside that window extends it, so termination is never briefly switched back on between back-to-back reads.

While the device is in self-refresh, data termination is held off. It returns when the clock enable is sampled high again. The command/address termination enable is held on in every state.

Top module: `rsnoop_term_ctrl`

## Requirements
- R1: After reset, with no command in flight, `dq_term_en` and `ca_term_en` are both 1.
- R2: A READ is the encoding ras_n=1, cas_n=0, we_n=1, sampled with cke=1. It is recognised whatever the value of cs_n.
- R3: For a READ sampled at clock edge k, `dq_term_en` goes to 0 right after edge k+CL-1 and stays 1 before that edge. CL is `cas_lat`.
- R4: After the turn-off, `dq_term_en` stays 0 for BURST_CYC+1 cycles (5 by default) and then returns to 1.
- R5: A READ whose turn-off point falls inside an open off window reloads the window. `dq_term_en` stays 0 without a gap until BURST_CYC+1 cycles after the last turn-off point.
- R6: Commands that are not READs leave `dq_term_en` at 1. This covers WRITE (1,0,0), ACTIVATE (0,1,1), PRECHARGE (0,1,0), NOP (1,1,1) and REFRESH (0,0,1) with cke=1, where the triple is (ras_n, cas_n, we_n).
- R7: `ca_term_en` is 1 in every cycle.
- R8: Self-refresh entry is cs_n=0 with REFRESH encoding (0,0,1) and cke=0. `dq_term_en` is 0 from the next edge until the first edge that samples cke=1. Commands sampled while cke=0 are ignored.
- R9: `cas_lat` is taken at run time, for any value from 5 to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low with refresh command enters self-refresh |
| cs_n | input | 1 | Chip select, active low (ignored for READ detection) |
| ras_n | input | 1 | Row strobe command line, active low |
| cas_n | input | 1 | Column strobe command line, active low |
| we_n | input | 1 | Write enable command line, active low |
| cas_lat | input | 4 | CAS latency in cycles, 5 to 12 |
| dq_term_en | output | 1 | Data-line termination enable, 1 = on |
| ca_term_en | output | 1 | Command/address termination enable, always 1 |

## Verification
The assertions rely on `cas_lat` staying between 5 and 12. They also rely on it being held steady while a read is still moving through the delay line, because the tap that fires is chosen from the current value. The stimulus sets the latency only while the bus is idle, and it waits for the pipeline and the off window to drain before the next change. Within each vector it uses latencies across the full legal range, both chip-select values, and a self-refresh episode during which a READ encoding is offered and must be ignored.

// File: rtl/rsnoop_pkg.sv
package rsnoop_pkg;

    localparam int MIN_CL    = 5;
    localparam int MAX_CL    = 12;
    localparam int CL_W      = 4;
    localparam int BURST_CYC = 4;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_READ,
        K_WRITE,
        K_REFRESH,
        K_OTHER
    } cmd_kind_e;

    function automatic cmd_kind_e classify(bus_cmd_t c);
        case ({c.ras_n, c.cas_n, c.we_n})
            3'b111:  return K_NOP;
            3'b101:  return K_READ;
            3'b100:  return K_WRITE;
            3'b001:  return K_REFRESH;
            default: return K_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/rsnoop_cmd_decode.sv
module rsnoop_cmd_decode
    import rsnoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cke,
    input  logic     cs_n,
    input  bus_cmd_t cmd,
    output logic     read_hit,
    output logic     in_srf
);

    cmd_kind_e kind;
    logic      srf_entry;

    always_comb begin
        kind      = classify(cmd);
        // chip select deliberately left out of the read decode
        read_hit  = cke && !in_srf && (kind == K_READ);
        srf_entry = !cke && !cs_n && !in_srf && (kind == K_REFRESH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_srf <= 1'b0;
        end else if (in_srf && cke) begin
            in_srf <= 1'b0;
        end else if (srf_entry) begin
            in_srf <= 1'b1;
        end
    end

    p_srf_enter_r8: assert property (@(posedge clk) disable iff (rst)
        (!cke && !cs_n && !cmd.ras_n && !cmd.cas_n && cmd.we_n) |=> in_srf);

    p_srf_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (in_srf && cke) |=> !in_srf);

    p_read_needs_cke_r2: assert property (@(posedge clk) disable iff (rst)
        read_hit |-> cke);

endmodule

// File: rtl/rsnoop_delay_line.sv
module rsnoop_delay_line
    import rsnoop_pkg::*;
#(
    parameter int MAXL = MAX_CL,
    parameter int LW   = CL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_in,
    input  logic [LW-1:0] cas_lat,
    output logic          tap_out
);

    localparam int DEPTH = MAXL - 1;

    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= hit_in;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= 1'b0;
            else     stage[g] <= stage[g-1];
        end
        p_shift_r3: assert property (@(posedge clk) disable iff (rst)
            stage[g-1] |=> stage[g]);
    end

    // stage[CL-2] holds a read seen CL-1 edges before the next edge
    always_comb begin
        tap_out = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LW'(i + 2) == cas_lat) tap_out = stage[i];
        end
    end

    p_enter_r3: assert property (@(posedge clk) disable iff (rst)
        hit_in |=> stage[0]);

    p_cl_range_r9: assert property (@(posedge clk) disable iff (rst)
        (cas_lat >= LW'(MIN_CL)) && (cas_lat <= LW'(MAXL)));

endmodule

// File: rtl/rsnoop_off_window.sv
module rsnoop_off_window
    import rsnoop_pkg::*;
#(
    parameter int BURST = BURST_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic window_open
);

    localparam int WIN = BURST + 1;
    localparam int CW  = $clog2(WIN + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(WIN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign window_open = (remain != '0);

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> (remain == CW'(WIN)));

    p_count_r4: assert property (@(posedge clk) disable iff (rst)
        (!start && remain != '0) |=> (remain == $past(remain) - 1'b1));

    p_extend_r5: assert property (@(posedge clk) disable iff (rst)
        (start && window_open) |=> window_open);

endmodule

// File: rtl/rsnoop_term_ctrl.sv
module rsnoop_term_ctrl
    import rsnoop_pkg::*;
#(
    parameter int MAXL  = MAX_CL,
    parameter int LW    = CL_W,
    parameter int BURST = BURST_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [LW-1:0] cas_lat,
    output logic          dq_term_en,
    output logic          ca_term_en
);

    bus_cmd_t cmd;
    logic     read_hit;
    logic     in_srf;
    logic     tap;
    logic     off_win;

    assign cmd = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    rsnoop_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cs_n     (cs_n),
        .cmd      (cmd),
        .read_hit (read_hit),
        .in_srf   (in_srf)
    );

    rsnoop_delay_line #(.MAXL(MAXL), .LW(LW)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .hit_in  (read_hit),
        .cas_lat (cas_lat),
        .tap_out (tap)
    );

    rsnoop_off_window #(.BURST(BURST)) u_win (
        .clk         (clk),
        .rst         (rst),
        .start       (tap),
        .window_open (off_win)
    );

    assign dq_term_en = !(in_srf || off_win);
    assign ca_term_en = 1'b1;

    p_turn_off_r3: assert property (@(posedge clk) disable iff (rst)
        tap |=> !dq_term_en);

    p_srf_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!cke && !cs_n && !ras_n && !cas_n && we_n) |=> !dq_term_en);

endmodule

// File: tb/rsnoop_term_ctrl_tb.sv
module rsnoop_term_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [3:0] cas_lat = 4'd5;
    logic       dq_term_en;
    logic       ca_term_en;

    int checks = 0;
    int fails  = 0;

    localparam int WIN = 5;

    always #10 clk = ~clk;

    rsnoop_term_ctrl u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cas_lat(cas_lat),
        .dq_term_en(dq_term_en), .ca_term_en(ca_term_en)
    );

    // {cl[3:0], cs_n, ras_n, cas_n, we_n, is_read}
    localparam logic [8:0] VEC [10] = '{
        {4'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd8,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd6,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd9,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd6,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'd11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic set_nop();
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic idle(input int n);
        set_nop();
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R7 reset state
        check(dq_term_en, 1'b1, "R1", "dq after reset");
        check(ca_term_en, 1'b1, "R1", "ca after reset");

        // table walk: R2 R3 R4 R6 R9
        foreach (VEC[v]) begin
            int cl;
            logic rd;
            cl = int'(VEC[v][8:5]);
            rd = VEC[v][0];
            cas_lat = VEC[v][8:5];
            idle(2);
            cs_n = VEC[v][4]; ras_n = VEC[v][3]; cas_n = VEC[v][2]; we_n = VEC[v][1];
            @(negedge clk);
            set_nop();
            for (int j = 0; j < 20; j++) begin
                logic exp;
                exp = !(rd && j >= cl - 1 && j < cl - 1 + WIN);
                check(dq_term_en, exp, rd ? "R3_R4_R2_R9" : "R6",
                      $sformatf("vec %0d cycle %0d", v, j));
                check(ca_term_en, 1'b1, "R7", $sformatf("vec %0d cycle %0d", v, j));
                @(negedge clk);
            end
        end

        // R5 back-to-back reads two cycles apart, CL=7
        cas_lat = 4'd7;
        idle(2);
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        set_nop();
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        set_nop();
        for (int j = 2; j < 20; j++) begin
            check(dq_term_en, !(j >= 6 && j <= 12), "R5", $sformatf("b2b cycle %0d", j));
            @(negedge clk);
        end

        // R8 self-refresh with an ignored read inside
        cas_lat = 4'd5;
        idle(2);
        cke = 1'b0; cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        check(dq_term_en, 1'b0, "R8", "entry");
        check(ca_term_en, 1'b1, "R7", "in self-refresh");
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        set_nop();
        for (int j = 0; j < 6; j++) begin
            check(dq_term_en, 1'b0, "R8", $sformatf("held cycle %0d", j));
            @(negedge clk);
        end
        cke = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 12; j++) begin
            check(dq_term_en, 1'b1, "R8", $sformatf("after exit cycle %0d", j));
            @(negedge clk);
        end

        // R1 reset during an open window
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        set_nop();
        repeat (5) @(negedge clk);
        check(dq_term_en, 1'b0, "R4", "window open before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 12; j++) begin
            check(dq_term_en, 1'b1, "R1", $sformatf("post reset cycle %0d", j));
            @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule